// File: doc/BRIEF.md
# Shared-Timer Multi-Key Debouncer

This block cleans up a bank of mechanical key inputs with one common lockout timer rather than a counter per key. While the block is idle, a change on any key is copied to the debounced outputs straight away, so the first edge of a press or release reaches the system with no stable-period wait. That acceptance starts a shared lockout window, and all further level changes on every key are disregarded until the window runs out. The bounce that follows an edge is hidden this way.

When the window ends, the synchronized inputs are compared with the debounced outputs. If any key differs, the new state is taken at once and the window starts again. If no key differs, the block goes back to idle. The window is counted in ticks of a slow prescaler, so the lockout counter needs only a few bits. A one-cycle change strobe per key marks every toggle of a debounced output.

Top module: `keyDebounce`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `keyOut` equals the released level `RELEASED_LVL` (default 0) and `keyChg` is all zero.
- R2: In the idle state, a raw input change made between clock edges shows on `keyOut` after the third rising edge: two edges of synchronizer and one edge of output register. After the second edge the old value is still present.
- R3: `keyChg[k]` is 1 for exactly the one cycle in which `keyOut[k]` takes a new value, and 0 in all other cycles.
- R4: After each acceptance, `keyOut` holds its value for exactly `TICK_DIV*LOCK_TICKS` clock cycles, whatever the raw inputs do in that time.
- R5: If the synchronized inputs differ from `keyOut` when the window ends, the new state is taken on that edge and a full new window starts.
- R6: If the synchronized inputs equal `keyOut` when the window ends, nothing changes (`keyChg` stays 0) and the block returns to idle. The next change then passes with the R2 latency.
- R7: Changes on several keys that are synchronized in the same cycle are taken together in one update, and `keyChg` then shows all of them at once.
- R8: From any output state, any 8-bit input pattern held through the window ends up on `keyOut` unchanged, and `keyChg` equals the old state XOR the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keyRaw | input | NUM_KEYS | Raw, asynchronous key levels |
| keyOut | output | NUM_KEYS | Debounced key levels |
| keyChg | output | NUM_KEYS | One-cycle strobe per key whose debounced level toggled |

## Verification
The bench uses a small configuration with four clocks per tick and three ticks per window. It applies three kinds of input patterns. Single-key walks show that only the touched key moves. Bursts of rapid toggling inside the window show that the lockout masks bounce on every key. Changes placed just before the window ends show its exact length and the restart. A sweep of all 256 input patterns, each one reached from the previous pattern, then checks that every multi-key transition lands whole and that the strobe mask equals the XOR of the two states.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_LOCK = 1'b1} kdbState_e;

  typedef struct packed {
    logic accept;   // copy synchronized keys to outputs this cycle
    logic restart;  // zero the lockout timer
  } kdbCtl_t;
endpackage

// File: rtl/kdb_prescale.sv
module kdb_prescale #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] preCnt;

  assign tick = run && (preCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      preCnt <= '0;
    end else if (run) begin
      if (preCnt == LAST) preCnt <= '0;
      else                preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/kdb_datapath.sv
module kdb_datapath
  import kdb_pkg::*;
#(
  parameter int NUM_KEYS     = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit RELEASED_LVL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyRaw,
  input  kdbCtl_t             ctl,
  output logic [NUM_KEYS-1:0] keySync,
  output logic [NUM_KEYS-1:0] keyOut,
  output logic [NUM_KEYS-1:0] keyChg,
  output logic                diffAny
);
  localparam logic [NUM_KEYS-1:0] REL_VEC = {NUM_KEYS{RELEASED_LVL}};

  logic [NUM_KEYS-1:0] syncPipe [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst)         syncPipe[s] <= REL_VEC;
      else if (s == 0) syncPipe[s] <= keyRaw;
      else             syncPipe[s] <= syncPipe[(s > 0) ? s - 1 : 0];
    end
  end

  assign keySync = syncPipe[SYNC_STAGES-1];
  assign diffAny = |(keySync ^ keyOut);

  always_ff @(posedge clk) begin
    if (rst) begin
      keyOut <= REL_VEC;
      keyChg <= '0;
    end else if (ctl.accept) begin
      keyOut <= keySync;
      keyChg <= keySync ^ keyOut;
    end else begin
      keyChg <= '0;
    end
  end
endmodule

// File: rtl/kdb_control.sv
module kdb_control
  import kdb_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int LOCK_TICKS = 20
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    diffAny,
  output kdbCtl_t ctl,
  output logic    inLock
);
  localparam int CW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(LOCK_TICKS - 1);

  kdbState_e state;
  logic [CW-1:0] tickCnt;
  logic tick;
  logic expire;

  assign inLock = (state == ST_LOCK);
  assign expire = tick && (tickCnt == LAST_TICK);

  always_comb begin
    ctl.accept  = diffAny && (!inLock || expire);
    ctl.restart = ctl.accept;
  end

  kdb_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (inLock),
    .clr (ctl.restart),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      if (ctl.restart || expire) tickCnt <= '0;
      else if (tick)             tickCnt <= tickCnt + 1'b1;

      if (ctl.accept)  state <= ST_LOCK;
      else if (expire) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/keyDebounce.sv
module keyDebounce
  import kdb_pkg::*;
#(
  parameter int NUM_KEYS     = 8,
  parameter int TICK_DIV     = 50000,
  parameter int LOCK_TICKS   = 20,
  parameter int SYNC_STAGES  = 2,
  parameter bit RELEASED_LVL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyRaw,
  output logic [NUM_KEYS-1:0] keyOut,
  output logic [NUM_KEYS-1:0] keyChg
);
  kdbCtl_t             ctl;
  logic [NUM_KEYS-1:0] keySync;
  logic                diffAny;
  logic                inLock;

  kdb_datapath #(
    .NUM_KEYS    (NUM_KEYS),
    .SYNC_STAGES (SYNC_STAGES),
    .RELEASED_LVL(RELEASED_LVL)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .keyRaw (keyRaw),
    .ctl    (ctl),
    .keySync(keySync),
    .keyOut (keyOut),
    .keyChg (keyChg),
    .diffAny(diffAny)
  );

  kdb_control #(
    .TICK_DIV  (TICK_DIV),
    .LOCK_TICKS(LOCK_TICKS)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .diffAny(diffAny),
    .ctl    (ctl),
    .inLock (inLock)
  );
endmodule

// File: rtl/keyDebounce_chk.sv
module keyDebounce_chk #(
  parameter int NUM_KEYS     = 8,
  parameter int TICK_DIV     = 50000,
  parameter int LOCK_TICKS   = 20,
  parameter bit RELEASED_LVL = 1'b0
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_KEYS-1:0] keyOut,
  input logic [NUM_KEYS-1:0] keyChg,
  input logic [NUM_KEYS-1:0] keySync,
  input logic                inLock
);
  localparam int WIN = TICK_DIV * LOCK_TICKS;
  localparam int GW  = $clog2(WIN + 1);
  localparam logic [GW-1:0] WIN_V = GW'(WIN);
  localparam logic [NUM_KEYS-1:0] REL_VEC = {NUM_KEYS{RELEASED_LVL}};

  logic          rstQ;
  logic          armed;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (|keyChg) begin
      armed <= 1'b1;
      gap   <= GW'(1);
    end else if (gap != WIN_V) begin
      gap <= gap + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rstQ) begin
      AST_RESET_RELEASED: assert (keyOut == REL_VEC && keyChg == '0); // R1
    end
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!inLock && keySync != keyOut) |=> keyOut == $past(keySync)); // R2

  AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (rst)
    keyChg == (keyOut ^ $past(keyOut))); // R3

  AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (rst)
    (armed && |keyChg) |-> gap >= WIN_V); // R4
endmodule

bind keyDebounce keyDebounce_chk #(
  .NUM_KEYS    (NUM_KEYS),
  .TICK_DIV    (TICK_DIV),
  .LOCK_TICKS  (LOCK_TICKS),
  .RELEASED_LVL(RELEASED_LVL)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .keyOut (keyOut),
  .keyChg (keyChg),
  .keySync(keySync),
  .inLock (inLock)
);

// File: tb/keyDebounce_tb.sv
module keyDebounce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NK  = 8;
  localparam int TD  = 4;
  localparam int LT  = 3;
  localparam int WIN = TD * LT;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NK-1:0] keyRaw = '0;
  logic [NK-1:0] keyOut;
  logic [NK-1:0] keyChg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyDebounce #(
    .NUM_KEYS(NK), .TICK_DIV(TD), .LOCK_TICKS(LT),
    .SYNC_STAGES(2), .RELEASED_LVL(1'b0)
  ) u_dut (
    .clk(clk), .rst(rst), .keyRaw(keyRaw), .keyOut(keyOut), .keyChg(keyChg)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NK-1:0] act, input logic [NK-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic [NK-1:0] cur, nxt, x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 keyOut in reset", keyOut, '0);
    rst = 1'b0;
    step(1);
    check("R1 keyOut after reset", keyOut, '0);
    check("R1 keyChg after reset", keyChg, '0);
    cur = '0;

    // R2 / R3: walk one key at a time
    for (int k = 0; k < NK; k++) begin
      nxt = NK'(1) << k;
      keyRaw = nxt;
      step(LAT - 1);
      check("R2 not yet passed", keyOut, cur);
      step(1);
      check("R2 passed at third edge", keyOut, nxt);
      check("R3 strobe mask", keyChg, cur ^ nxt);
      step(1);
      check("R3 strobe one cycle", keyChg, '0);
      cur = nxt;
      step(WIN);
    end

    // R4 / R6: bounce inside window is masked
    nxt = 8'h3C;
    keyRaw = nxt;
    step(LAT);
    check("R2 burst start", keyOut, nxt);
    cur = nxt;
    for (int j = 0; j < 8; j++) begin
      keyRaw = cur ^ NK'((j * 53 + 7) & 8'hFF);
      step(1);
      check("R4 output held during bounce", keyOut, cur);
    end
    keyRaw = cur;
    step(3);
    check("R4 held before expiry", keyOut, cur);
    step(1);
    check("R6 no change at expiry", keyOut, cur);
    check("R6 no strobe at expiry", keyChg, '0);
    nxt = 8'hC1;
    keyRaw = nxt;
    step(LAT - 1);
    check("R6 idle again, not yet", keyOut, cur);
    step(1);
    check("R6 idle again, passed", keyOut, nxt);
    cur = nxt;

    // R4 / R5: change held across expiry, exact window, restart
    step(2);
    x = cur ^ 8'h81;
    keyRaw = x;
    step(WIN - 3);
    check("R4 exact window, last held cycle", keyOut, cur);
    step(1);
    check("R5 taken at expiry", keyOut, x);
    check("R5 strobe at expiry", keyChg, cur ^ x);
    keyRaw = cur;
    step(WIN - 1);
    check("R5 restarted window holds", keyOut, x);
    step(1);
    check("R5 second expiry takes change", keyOut, cur);
    step(WIN);

    // R7: every key at once
    nxt = ~cur;
    keyRaw = nxt;
    step(LAT);
    check("R7 all keys together", keyOut, nxt);
    check("R7 all strobes together", keyChg, 8'hFF);
    cur = nxt;
    step(WIN);

    // R8: sweep of all 256 patterns
    for (int i = 0; i < 256; i++) begin
      nxt = NK'((i * 167 + 13) & 8'hFF);
      keyRaw = nxt;
      step(LAT);
      check("R8 sweep output", keyOut, nxt);
      check("R8 sweep strobe", keyChg, cur ^ nxt);
      cur = nxt;
      step(WIN);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule